// File: doc/BRIEF.md
# Comparator Hit Pulse Shaper

This block converts the level outputs of a bank of threshold discriminators into one hit bit per channel per clock period. The result is written into a trigger-latency pipeline. A discriminator output is asynchronous to the 40 MHz sampling clock, so one clock period is a 25 ns timeslice. It stays high for as long as the amplified signal is above threshold, which can cover several timeslices. Each channel first passes through a multi-flop synchroniser. A per-channel shaping cell then produces the registered hit bit.

Two configuration inputs select the shaping. With shaping enabled, the mode input chooses between two behaviours. In single mode any firing, whatever its length, becomes exactly one timeslice of hit. In variable mode the hit lasts as long as the discriminator stays high, so larger signals give longer windows. With shaping disabled, the synchronised level is passed to the output unchanged. The channel count and the synchroniser depth are parameters.

Top module: `cmp_hit_shaper`

## Requirements
- R1: While reset is asserted every hit output is 0. Reset clears the synchroniser and the edge history, so after release no hit comes from a level that was captured before reset.
- R2: A change on a discriminator input first shows on the hit output after SYNC_STAGES+1 rising clock edges, which is 3 edges with the default depth of 2.
- R3: With shape_en_i=1 and mode_var_i=0 (single mode), a low-to-high transition of the synchronised level produces a hit that lasts exactly one clock cycle, whatever the pulse length.
- R4: In single mode a level that stays high produces no further hit. A new hit comes only after the level has been low for at least one cycle and rises again.
- R5: With shape_en_i=1 and mode_var_i=1 (variable mode), the hit is high in every cycle in which the synchronised level is high, so the hit length equals the pulse length in cycles.
- R6: With shape_en_i=0 the hit output equals the synchronised level, with the latency of R2, for either value of mode_var_i.
- R7: Channels are shaped independently: a hit on one channel does not depend on the activity of any other channel.
- R8: N_CH (default 128) sets the width of cmp_i and hit_o. SYNC_STAGES must be at least 2, and elaboration rejects smaller values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 40 MHz sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | N_CH | Asynchronous discriminator levels, one per channel |
| shape_en_i | input | 1 | 1 applies shaping, 0 passes the synchronised level through |
| mode_var_i | input | 1 | 0 selects single mode, 1 selects variable mode |
| hit_o | output | N_CH | Registered hit bit per channel per timeslice |

## Verification
Single-mode stimulus includes one-cycle pulses, long pulses and a pulse broken by a one-cycle low gap. Long pulses separate a true edge detector from a level follower. The broken pulse shows whether the cell re-arms after the minimum low time. Variable mode and bypass are driven with pulses of several lengths, so a clipped or stretched hit shows up as a length mismatch. Random multi-channel patterns in every configuration expose cross-channel coupling and latency errors. A reset applied while all channels are high shows whether stale synchroniser content leaks out after release.

// File: rtl/hitshp_pkg.sv
package hitshp_pkg;

   // Shaping behaviour selected when shaping is enabled
   typedef enum logic {
      SHAPE_SINGLE   = 1'b0,
      SHAPE_VARIABLE = 1'b1
   } shape_mode_e;

   // Minimum synchroniser depth accepted by the library
   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/hitshp_sync.sv
module hitshp_sync #(
   parameter int unsigned WIDTH  = 128,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   import hitshp_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
         $error("hitshp_sync: STAGES below minimum depth");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hitshp_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stg_q[k] <= '0;
               else         stg_q[k] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stg_q[k] <= '0;
               else         stg_q[k] <= stg_q[k-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[LAST];

endmodule

// File: rtl/hitshp_cell.sv
module hitshp_cell
   import hitshp_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        lvl_i,
   input  logic        en_i,
   input  shape_mode_e mode_i,
   output logic        hit_o
);

   logic prev_q;
   logic hit_q;
   logic hit_d;

   // Shaping selection: bypass, one-slice edge, or level follower
   always_comb begin
      if (!en_i)                      hit_d = lvl_i;
      else if (mode_i == SHAPE_SINGLE) hit_d = lvl_i & ~prev_q;
      else                             hit_d = lvl_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         hit_q  <= hit_d;
      end
   end

   assign hit_o = hit_q;

   // R3: two back-to-back single-mode hits cannot occur
   p_single_slice_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_q && $past(en_i) && ($past(mode_i) == SHAPE_SINGLE)
             && $past(en_i, 2) && ($past(mode_i, 2) == SHAPE_SINGLE))
      |-> !$past(hit_q));

   // R4: a single-mode hit needs the level low one cycle before it rose
   p_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_q && $past(en_i) && ($past(mode_i) == SHAPE_SINGLE))
      |-> ($past(lvl_i) && !$past(lvl_i, 2)));

   // R5: variable mode holds the hit while the level is high
   p_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(en_i) && ($past(mode_i) == SHAPE_VARIABLE) && $past(lvl_i))
      |-> hit_q);

   // R6: bypass passes the synchronised level one cycle later
   p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(en_i) |-> (hit_q == $past(lvl_i)));

endmodule

// File: rtl/cmp_hit_shaper.sv
module cmp_hit_shaper
   import hitshp_pkg::*;
#(
   parameter int unsigned N_CH        = 128,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [N_CH-1:0] cmp_i,
   input  logic            shape_en_i,
   input  logic            mode_var_i,
   output logic [N_CH-1:0] hit_o
);

   // Input-to-output latency in rising edges (documented, R2)
   localparam int unsigned LATENCY = SYNC_STAGES + 1;

   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("cmp_hit_shaper: N_CH must be at least 1");
      end
      if (LATENCY < MIN_SYNC_STAGES + 1) begin : g_bad_lat
         $error("cmp_hit_shaper: SYNC_STAGES below minimum (R8)");
      end
   endgenerate

   logic [N_CH-1:0] lvl_s;
   shape_mode_e     mode_s;

   assign mode_s = shape_mode_e'(mode_var_i);

   hitshp_sync #(
      .WIDTH  (N_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cmp_i),
      .q_o    (lvl_s)
   );

   // R7: one independent shaping cell per channel
   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         hitshp_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lvl_i  (lvl_s[c]),
            .en_i   (shape_en_i),
            .mode_i (mode_s),
            .hit_o  (hit_o[c])
         );
      end
   endgenerate

   // R1: outputs are cleared whenever reset is held
   p_reset_clear_r1: assert property (@(posedge clk_i)
      !rst_ni |-> (hit_o == '0));

endmodule

// File: tb/sim_cmp_hit_shaper.sv
`timescale 1ns/1ps
module sim_cmp_hit_shaper;

   localparam int N   = 128;
   localparam int LAT = 3;

   logic         clk   = 1'b0;
   logic         rst_n = 1'b1;
   logic [N-1:0] cmp   = '0;
   logic         en    = 1'b1;
   logic         mvar  = 1'b0;
   logic [N-1:0] hit;

   typedef struct {
      logic [N-1:0] exp;
      int           due;
      string        tag;
   } item_t;

   item_t        sb_q[$];
   int           edges  = 0;
   int           checks = 0;
   int           fails  = 0;
   logic [N-1:0] vprev  = '0;

   always #10 clk = ~clk;

   cmp_hit_shaper #(.N_CH(N), .SYNC_STAGES(2)) u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cmp_i      (cmp),
      .shape_en_i (en),
      .mode_var_i (mvar),
      .hit_o      (hit)
   );

   // Monitor: compares outputs against items that have come due
   always @(posedge clk) begin
      edges++;
      #2;
      while (sb_q.size() > 0 && sb_q[0].due <= edges) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (hit !== it.exp) begin
            fails++;
            $display("FAIL %s: hit_o=%h expected %h", it.tag, hit, it.exp);
         end
      end
   end

   // Driver: applies one input vector and queues the expected output
   task automatic step(input logic [N-1:0] v, input string tag);
      logic [N-1:0] e;
      @(negedge clk);
      cmp = v;
      if (!en)       e = v;
      else if (mvar) e = v;
      else           e = v & ~vprev;
      sb_q.push_back('{e, edges + LAT, tag});
      vprev = v;
   endtask

   task automatic pulse(input logic [N-1:0] v, input int len, input string tag);
      for (int i = 0; i < len; i++) step(v, tag);
   endtask

   task automatic set_cfg(input logic e, input logic m);
      for (int i = 0; i < 4; i++) step('0, "cfg");
      @(negedge clk);
      en   = e;
      mvar = m;
      for (int i = 0; i < 4; i++) step('0, "cfg");
   endtask

   task automatic check_now(input logic [N-1:0] exp, input string tag);
      checks++;
      if (hit !== exp) begin
         fails++;
         $display("FAIL %s: hit_o=%h expected %h", tag, hit, exp);
      end
   endtask

   function automatic logic [N-1:0] rnd_vec();
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = 1'($urandom_range(0, 1));
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements): edges=%0d expected run end", edges);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [N-1:0] a;
      // R1: reset state
      #1 rst_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_now('0, "R1 reset state");
      end
      @(negedge clk);
      rst_n = 1'b1;

      // Single mode: R3 and R2
      set_cfg(1'b1, 1'b0);
      pulse(128'h1, 1, "R3 one-cycle pulse");
      pulse('0, 3, "R2 quiet after pulse");
      pulse(128'h20, 6, "R3 long pulse clipped");
      pulse('0, 2, "R3");
      pulse('1, 3, "R3 all channels");
      pulse('0, 2, "R3");
      // R4: gap of one cycle re-arms, steady high does not
      pulse(128'h80, 2, "R4 first rise");
      pulse('0, 1, "R4 one-cycle gap");
      pulse(128'h80, 10, "R4 second rise then hold");
      pulse('0, 2, "R4");

      // Variable mode: R5 and R2
      set_cfg(1'b1, 1'b1);
      pulse(128'h2, 1, "R2 variable latency");
      pulse('0, 3, "R2");
      pulse(128'h4, 3, "R5 three-slice pulse");
      pulse('0, 1, "R5");
      pulse({64'h0, 64'hF0F0}, 8, "R5 eight-slice pulse");
      pulse('0, 2, "R5");
      // R7: random multi-channel patterns, variable then single
      for (int i = 0; i < 40; i++) step(rnd_vec(), "R7 variable random");
      set_cfg(1'b1, 1'b0);
      for (int i = 0; i < 40; i++) begin
         a = rnd_vec() | rnd_vec();
         step(a, "R7 single random");
      end

      // Bypass: R6 in both mode settings
      set_cfg(1'b0, 1'b0);
      pulse(128'h100, 5, "R6 bypass long pulse");
      pulse('0, 1, "R6");
      for (int i = 0; i < 20; i++) step(rnd_vec(), "R6 bypass random");
      set_cfg(1'b0, 1'b1);
      for (int i = 0; i < 20; i++) step(rnd_vec(), "R6 bypass variable");

      // R1: reset while every channel is high
      set_cfg(1'b1, 1'b1);
      pulse('1, 5, "R1 before reset");
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      cmp   = '0;
      vprev = '0;
      #2 check_now('0, "R1 outputs cleared in reset");
      @(negedge clk);
      check_now('0, "R1 held in reset");
      @(negedge clk);
      rst_n = 1'b1;
      pulse('0, 5, "R1 no stale hit after release");

      pulse('0, 4, "end");
      repeat (LAT + 2) @(posedge clk);
      #5;
      checks++;
      if (sb_q.size() != 0) begin
         fails++;
         $display("FAIL R2: %0d items pending expected 0", sb_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule